// File: doc/BRIEF.md
# Block Carry-Select Adder

A purely combinational two-operand adder. Its word is cut into equal slices. The lowest slice is one adder fed directly by the incoming carry. Every slice above it holds two adders that work at the same time: one assumes a carry-in of 0 and the other a carry-in of 1. When the real carry reaches a slice boundary, it only steers a 2:1 multiplexer. That multiplexer picks both the slice's sum bits and its carry-out from whichever precomputed result was right. The carry path therefore becomes a chain of multiplexers, one per slice, instead of a ripple through every bit.

The word width and the slice width are parameters. A third parameter chooses how each slice adder forms its internal carries: a chain of full-adder cells, or flattened generate/propagate lookahead terms. The default build is a 16-bit word made of four 4-bit slices.

Top module: `csa_adder`

## Requirements
- R1: For every input, the concatenation {cout, sum} equals the arithmetic value a + b + cin, taken as WIDTH+1 bits.
- R2: With a all ones, b zero and cin 1, sum is all zeros and cout is 1, because the carry passes through every slice.
- R3: For every slice k above the lowest, the carry that selects its result equals the true carry out of bits 0 to k·BLK−1. Its sum bits equal (a_k + b_k + that carry) mod 2^BLK.
- R4: For every upper slice, the carry-1 result {carry, sum} equals the carry-0 result plus one. A carry out of the carry-0 adder implies a carry out of the carry-1 adder.
- R5: The lowest slice uses cin directly, so sum[BLK−1:0] equals (a[BLK−1:0] + b[BLK−1:0] + cin) mod 2^BLK.
- R6: cout is the selected carry of the top slice. For example, a = b = 2^(WIDTH−1) with cin 0 gives sum 0 and cout 1.
- R7: WIDTH must be a positive multiple of BLK, and any other value fails elaboration. The chain variant and the lookahead variant of the slice adder give identical results.
- R8: With a = 0, b = 0 and cin = 0, sum is 0 and cout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Incoming carry |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Outgoing carry |

## Verification
The bench builds two copies of the adder. The first uses the defaults: a 16-bit word, 4-bit slices and chained full-adder cells. The second uses a 12-bit word, 3-bit slices and the lookahead slice variant. The second copy puts slice boundaries at bit positions the default never has, and it exercises the other generate branch. An exhaustive sweep over the low six bits of both operands, with both carry values, crosses the first slice boundary in each build. Directed patterns then force carries into each slice and past all of them.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;
   // Which internal carry scheme a slice adder uses
   typedef enum logic {
      CSA_CHAIN     = 1'b0,
      CSA_LOOKAHEAD = 1'b1
   } csa_slice_kind_e;
endpackage

// File: rtl/csa_fa.sv
`timescale 1ns/1ps
module csa_fa (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic hx;
   assign hx = x ^ y;
   assign s  = hx ^ ci;
   assign co = (x & y) | (hx & ci);
endmodule

// File: rtl/csa_slice_add.sv
`timescale 1ns/1ps
module csa_slice_add #(
   parameter int                       BW   = 4,
   parameter csa_pkg::csa_slice_kind_e KIND = csa_pkg::CSA_CHAIN
) (
   input  logic [BW-1:0] x,
   input  logic [BW-1:0] y,
   input  logic          ci,
   output logic [BW-1:0] s,
   output logic          co
);
   if (BW < 1) begin : g_bad_bw
      $error("csa_slice_add: BW must be at least 1");
   end

   logic [BW:0] c;
   assign c[0] = ci;
   assign co   = c[BW];

   if (KIND == csa_pkg::CSA_CHAIN) begin : g_chain
      for (genvar i = 0; i < BW; i++) begin : g_bit
         csa_fa u_fa (
            .x (x[i]),
            .y (y[i]),
            .ci(c[i]),
            .s (s[i]),
            .co(c[i+1])
         );
      end
   end else begin : g_look
      logic [BW-1:0] gen, prp;
      assign gen = x & y;
      assign prp = x ^ y;
      // every carry is a flat OR of generate terms masked by propagate runs
      always_comb begin
         logic run;
         for (int i = 0; i < BW; i++) begin
            c[i+1] = gen[i];
            run    = prp[i];
            for (int j = i - 1; j >= 0; j--) begin
               c[i+1] = c[i+1] | (run & gen[j]);
               run    = run & prp[j];
            end
            c[i+1] = c[i+1] | (run & ci);
         end
      end
      assign s = prp ^ c[BW-1:0];
   end
endmodule

// File: rtl/csa_sel_mux.sv
`timescale 1ns/1ps
module csa_sel_mux #(
   parameter int BW = 4
) (
   input  logic          sel,
   input  logic [BW-1:0] s_lo,
   input  logic          c_lo,
   input  logic [BW-1:0] s_hi,
   input  logic          c_hi,
   output logic [BW-1:0] s_out,
   output logic          c_out
);
   assign s_out = sel ? s_hi : s_lo;
   assign c_out = sel ? c_hi : c_lo;
endmodule

// File: rtl/csa_adder.sv
`timescale 1ns/1ps
module csa_adder #(
   parameter int                       WIDTH = 16,
   parameter int                       BLK   = 4,
   parameter csa_pkg::csa_slice_kind_e KIND  = csa_pkg::CSA_CHAIN
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int NBLK = (BLK > 0) ? WIDTH / BLK : 1;

   if (BLK < 1 || WIDTH < 1 || (WIDTH % BLK) != 0) begin : g_bad_geom
      $error("csa_adder: WIDTH must be a positive multiple of BLK");
   end

   // blk_cin[k] is the resolved carry entering slice k
   logic [NBLK:0]              blk_cin;
   logic [NBLK-1:0][BLK-1:0]   blk_sum0, blk_sum1;
   logic [NBLK-1:0]            blk_c0, blk_c1;

   assign blk_cin[0] = cin;
   assign cout       = blk_cin[NBLK];

   for (genvar k = 0; k < NBLK; k++) begin : g_slice
      if (k == 0) begin : g_base
         csa_slice_add #(.BW(BLK), .KIND(KIND)) u_add (
            .x (a[BLK-1:0]),
            .y (b[BLK-1:0]),
            .ci(blk_cin[0]),
            .s (blk_sum0[0]),
            .co(blk_c0[0])
         );
         assign blk_sum1[0]  = blk_sum0[0];
         assign blk_c1[0]    = blk_c0[0];
         assign sum[BLK-1:0] = blk_sum0[0];
         assign blk_cin[1]   = blk_c0[0];
      end else begin : g_upper
         csa_slice_add #(.BW(BLK), .KIND(KIND)) u_add0 (
            .x (a[k*BLK +: BLK]),
            .y (b[k*BLK +: BLK]),
            .ci(1'b0),
            .s (blk_sum0[k]),
            .co(blk_c0[k])
         );
         csa_slice_add #(.BW(BLK), .KIND(KIND)) u_add1 (
            .x (a[k*BLK +: BLK]),
            .y (b[k*BLK +: BLK]),
            .ci(1'b1),
            .s (blk_sum1[k]),
            .co(blk_c1[k])
         );
         csa_sel_mux #(.BW(BLK)) u_mux (
            .sel  (blk_cin[k]),
            .s_lo (blk_sum0[k]),
            .c_lo (blk_c0[k]),
            .s_hi (blk_sum1[k]),
            .c_hi (blk_c1[k]),
            .s_out(sum[k*BLK +: BLK]),
            .c_out(blk_cin[k+1])
         );
      end
   end
endmodule

// File: rtl/csa_adder_chk.sv
`timescale 1ns/1ps
module csa_adder_chk #(
   parameter int WIDTH = 16,
   parameter int BLK   = 4
) (
   input logic [WIDTH-1:0]                a,
   input logic [WIDTH-1:0]                b,
   input logic                            cin,
   input logic [WIDTH-1:0]                sum,
   input logic                            cout,
   input logic [WIDTH/BLK:0]              blk_cin,
   input logic [WIDTH/BLK-1:0][BLK-1:0]   blk_sum0,
   input logic [WIDTH/BLK-1:0][BLK-1:0]   blk_sum1,
   input logic [WIDTH/BLK-1:0]            blk_c0,
   input logic [WIDTH/BLK-1:0]            blk_c1
);
   localparam int NBLK = WIDTH / BLK;

   logic [WIDTH:0] full;
   logic [WIDTH:0] part;
   logic [WIDTH:0] mask;
   logic [BLK:0]   lo_ref;
   logic [BLK:0]   inc;

   always_comb begin
      full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      // R1: whole result matches arithmetic sum
      a_r1_total: assert ({cout, sum} == full)
         else $error("R1 total mismatch");
      // R6: outgoing carry is the top slice carry
      a_r6_cout: assert (cout == full[WIDTH])
         else $error("R6 cout mismatch");
      lo_ref = {1'b0, a[BLK-1:0]} + {1'b0, b[BLK-1:0]} + {{BLK{1'b0}}, cin};
      // R5: lowest slice sees cin directly
      a_r5_base_slice: assert (sum[BLK-1:0] == lo_ref[BLK-1:0])
         else $error("R5 base slice mismatch");
      for (int k = 1; k < NBLK; k++) begin
         mask = ({{WIDTH{1'b0}}, 1'b1} << (k * BLK)) - 1'b1;
         part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{WIDTH{1'b0}}, cin};
         // R3: select carry equals true carry from lower bits
         a_r3_select_carry: assert (blk_cin[k] == part[k*BLK])
            else $error("R3 select carry wrong at slice %0d", k);
         inc = {blk_c0[k], blk_sum0[k]} + {{BLK{1'b0}}, 1'b1};
         // R4: carry-1 result is carry-0 result plus one
         a_r4_pair_step: assert ({blk_c1[k], blk_sum1[k]} == inc)
            else $error("R4 precomputed pair inconsistent at slice %0d", k);
         a_r4_pair_monotone: assert (!blk_c0[k] || blk_c1[k])
            else $error("R4 carry-0 set without carry-1 at slice %0d", k);
      end
   end
endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH), .BLK(BLK)) u_chk (
   .a       (a),
   .b       (b),
   .cin     (cin),
   .sum     (sum),
   .cout    (cout),
   .blk_cin (blk_cin),
   .blk_sum0(blk_sum0),
   .blk_sum1(blk_sum1),
   .blk_c0  (blk_c0),
   .blk_c1  (blk_c1)
);

// File: tb/csa_adder_bench.sv
`timescale 1ns/1ps
module csa_adder_bench;
   localparam int W0 = 16;
   localparam int B0 = 4;
   localparam int W1 = 12;
   localparam int B1 = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;  // 250 MHz

   logic [W0-1:0] a, b;
   logic          cin;
   logic [W0-1:0] sum0;
   logic          cout0;
   logic [W1-1:0] sum1;
   logic          cout1;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // expected results pushed when driven, popped when sampled
   longint q_exp0[$];
   longint q_exp1[$];

   csa_adder #(.WIDTH(W0), .BLK(B0), .KIND(csa_pkg::CSA_CHAIN)) u_csa_adder (
      .a(a), .b(b), .cin(cin), .sum(sum0), .cout(cout0)
   );

   csa_adder #(.WIDTH(W1), .BLK(B1), .KIND(csa_pkg::CSA_LOOKAHEAD)) u_csa_adder_alt (
      .a(a[W1-1:0]), .b(b[W1-1:0]), .cin(cin), .sum(sum1), .cout(cout1)
   );

   task automatic apply(input longint va, input longint vb, input bit vc, input string req);
      longint e0, e1, g0, g1;
      @(posedge clk);
      a   <= va[W0-1:0];
      b   <= vb[W0-1:0];
      cin <= vc;
      e0 = (va & 64'hFFFF) + (vb & 64'hFFFF) + longint'(vc);
      e1 = (va & 64'hFFF) + (vb & 64'hFFF) + longint'(vc);
      q_exp0.push_back(e0);
      q_exp1.push_back(e1);
      @(negedge clk);
      e0 = q_exp0.pop_front();
      e1 = q_exp1.pop_front();
      g0 = longint'({cout0, sum0});
      g1 = longint'({cout1, sum1});
      vectors++;
      if (g0 != e0) begin
         miscompares++;
         $display("FAIL %s u_csa_adder a=%h b=%h cin=%0d got %h exp %h", req, va[W0-1:0], vb[W0-1:0], vc, g0, e0);
      end
      if (g1 != e1) begin
         miscompares++;
         $display("FAIL %s u_csa_adder_alt a=%h b=%h cin=%0d got %h exp %h", req, va[W1-1:0], vb[W1-1:0], vc, g1, e1);
      end
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0;
      // R8: all-zero inputs
      apply(0, 0, 0, "R8");
      // R2: carry through every slice
      apply(64'hFFFF, 0, 1, "R2");
      apply(64'hFFFF, 64'hFFFF, 1, "R2");
      // R6: carry produced only in the top slice
      apply(64'h8000, 64'h8000, 0, "R6");
      apply(64'h800, 64'h800, 0, "R6");
      // R3: force a carry into each slice boundary of both builds
      for (int k = 1; k <= 5; k++) begin
         apply((64'd1 << (k * 3)) - 1, 0, 1, "R3");
         apply((64'd1 << (k * 3)) - 1, 1, 0, "R3");
      end
      for (int k = 1; k <= 3; k++) begin
         apply((64'd1 << (k * 4)) - 1, 0, 1, "R3");
         apply((64'd1 << (k * 4)) - 1, 0, 0, "R3");
         apply(64'hF << (k * 4), 64'h1 << (k * 4), 0, "R3");
      end
      // R4: slice all ones with and without an incoming carry
      apply(64'h0F0F, 64'h0001, 0, "R4");
      apply(64'h0F0F, 64'h0001, 1, "R4");
      apply(64'h0FF0, 64'h0010, 0, "R4");
      // R5 / R1: exhaustive low six bits across the first boundary
      for (int x = 0; x < 64; x++)
         for (int y = 0; y < 64; y++)
            for (int c = 0; c < 2; c++)
               apply(longint'(x), longint'(y), c[0], "R5");
      // R1 / R7: random vectors on both builds
      for (int n = 0; n < 2000; n++)
         apply(longint'($urandom & 32'hFFFF), longint'($urandom & 32'hFFFF), $urandom % 2 == 1, "R7");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired got %0d vectors exp completion", vectors);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule